// File: doc/BRIEF.md
# Partial-Width Register File Write Unit

This block is a small general-purpose register file with one write port and two combinational read ports. Every entry is 64 bits wide by default and every read returns the whole entry. Along with its data, the write port takes a slice selector. The selector picks which part of the addressed entry the write lands in, and so what happens to the bits the write leaves uncovered.

There are five slices. A full write replaces the entry. A 32-bit write stores the low half and clears the upper half, so a later full-width read never sees stale upper bits. Three narrow writes merge into the entry and keep every bit they do not cover: the low 16 bits, the low byte, and the byte at bits 15:8. Narrow data always comes from the low end of the write-data bus, so software can place a byte in bits 15:8 without shifting it first.

A write takes effect on the rising clock edge. Reads are combinational from the stored state, so a read of the entry being written returns the old value until the following cycle.

Top module: `prf_regfile`

## Requirements
- R1: After reset every entry reads as zero on both read ports.
- R2: With write-enable high and slice code 0, the addressed entry takes all 64 bits of the write data.
- R3: With slice code 1, bits 31:0 of the entry take data bits 31:0 and bits 63:32 become zero. All ones followed by a slice-1 write of zero leaves the entry at zero.
- R4: With slice code 2, bits 15:0 take data bits 15:0 and bits 63:16 keep their previous value.
- R5: With slice code 3, bits 7:0 take data bits 7:0 and bits 63:8 keep their previous value, including the byte at 15:8.
- R6: With slice code 4, bits 15:8 take data bits 7:0, while bits 7:0 and 63:16 keep their previous value. Data bits 63:8 have no effect.
- R7: Slice codes 5, 6 and 7 cause no write: every entry keeps its value.
- R8: With write-enable low, no entry changes, whatever the slice code and data.
- R9: A read of an entry in the same cycle it is written returns the old value. The new value is visible from the next cycle on.
- R10: The two read ports return their own addressed entries independently, and a write never changes any entry other than the addressed one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 3 | Entry written |
| wr_slice | input | 3 | Slice code: 0 full, 1 low half with zero fill, 2 low 16, 3 low byte, 4 byte 15:8 |
| wr_data | input | 64 | Write data; narrow slices use the low bits |
| rd0_addr | input | 3 | Read port 0 entry select |
| rd0_data | output | 64 | Read port 0 data, full width |
| rd1_addr | input | 3 | Read port 1 entry select |
| rd1_data | output | 64 | Read port 1 data, full width |

## Verification
The case that is hardest to reach is one where a merge write has to keep bits it could silently clobber. Those bits only show up if the entry already holds a distinctive non-zero pattern, and if the write data carries non-zero bits outside the slice. Each narrow-slice scenario therefore first fills its entry with a full write of a pattern whose bytes all differ. The narrow write then drives garbage in the upper data bits, so a wrong source lane, a missing keep, or a missing zero fill each produces a visible miscompare. Read-during-write is reached by pointing a read port at the entry being written in the same cycle and sampling before the edge and again after it.

// File: rtl/prf_pkg.sv
package prf_pkg;

    // Slice codes on the write port; values outside this set are rejected.
    typedef enum logic [2:0] {
        SL_FULL  = 3'd0,
        SL_HALF  = 3'd1,
        SL_WORD  = 3'd2,
        SL_BYTE0 = 3'd3,
        SL_BYTE1 = 3'd4
    } slice_e;

    localparam int unsigned SLICE_CODE_W = 3;
    localparam int unsigned WORD_W       = 16;
    localparam int unsigned BYTE_W       = 8;

endpackage

// File: rtl/prf_slice_decode.sv
// Turns a slice code and raw write data into a keep mask (bits preserved
// from the old entry) and a placed value (new bits already in position).
module prf_slice_decode
    import prf_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [SLICE_CODE_W-1:0] slice,
    input  logic [DATA_W-1:0]       data,
    output logic                    valid,
    output logic [DATA_W-1:0]       keep_mask,
    output logic [DATA_W-1:0]       placed
);

    localparam int unsigned HALF_W = DATA_W / 2;

    always_comb begin
        valid     = 1'b1;
        keep_mask = '1;
        placed    = '0;
        case (slice)
            SL_FULL: begin
                keep_mask = '0;
                placed    = data;
            end
            SL_HALF: begin
                // upper half is not kept: it is forced to zero
                keep_mask              = '0;
                placed[HALF_W-1:0]     = data[HALF_W-1:0];
            end
            SL_WORD: begin
                keep_mask[WORD_W-1:0]  = '0;
                placed[WORD_W-1:0]     = data[WORD_W-1:0];
            end
            SL_BYTE0: begin
                keep_mask[BYTE_W-1:0]  = '0;
                placed[BYTE_W-1:0]     = data[BYTE_W-1:0];
            end
            SL_BYTE1: begin
                keep_mask[2*BYTE_W-1:BYTE_W] = '0;
                placed[2*BYTE_W-1:BYTE_W]    = data[BYTE_W-1:0];
            end
            default: begin
                valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/prf_entry_merge.sv
// Bitwise merge of the old entry with the placed write value.
module prf_entry_merge #(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] keep_mask,
    input  logic [DATA_W-1:0] placed,
    output logic [DATA_W-1:0] new_val
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign new_val[b] = keep_mask[b] ? old_val[b] : placed[b];
    end

endmodule

// File: rtl/prf_read_mux.sv
// One combinational read port over the packed storage.
module prf_read_mux #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 64,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [ADDR_W-1:0]               addr,
    output logic [DATA_W-1:0]               data
);

    assign data = regs[addr];

endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
    import prf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 64,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [SLICE_CODE_W-1:0] wr_slice,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd0_addr,
    output logic [DATA_W-1:0]       rd0_data,
    input  logic [ADDR_W-1:0]       rd1_addr,
    output logic [DATA_W-1:0]       rd1_data
);

    localparam int unsigned NUM_RD = 2;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    logic              slice_ok;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] merged;

    assign old_val = regs_q[wr_addr];

    prf_slice_decode #(.DATA_W(DATA_W)) u_decode (
        .slice     (wr_slice),
        .data      (wr_data),
        .valid     (slice_ok),
        .keep_mask (keep_mask),
        .placed    (placed)
    );

    prf_entry_merge #(.DATA_W(DATA_W)) u_merge (
        .old_val   (old_val),
        .keep_mask (keep_mask),
        .placed    (placed),
        .new_val   (merged)
    );

    // next-state process
    always_comb begin
        regs_d = regs_q;
        if (wr_en && slice_ok) begin
            regs_d[wr_addr] = merged;
        end
    end

    // state process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // read ports: combinational from stored state, so same-cycle writes
    // become visible only after the edge
    logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_a;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data_a;

    assign rd_addr_a[0] = rd0_addr;
    assign rd_addr_a[1] = rd1_addr;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        prf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
            .regs (regs_q),
            .addr (rd_addr_a[p]),
            .data (rd_data_a[p])
        );
    end

    assign rd0_data = rd_data_a[0];
    assign rd1_data = rd_data_a[1];

endmodule

// File: rtl/prf_regfile_checker.sv
module prf_regfile_checker #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 64,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
    localparam int unsigned HALF_W  = DATA_W / 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [2:0]                      wr_slice,
    input logic [DATA_W-1:0]               wr_data,
    input logic [ADDR_W-1:0]               rd0_addr,
    input logic [DATA_W-1:0]               rd0_data,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

    // R2: full write replaces the entry
    p_full_replace_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slice == 3'd0) |=> regs_q[$past(wr_addr)] == $past(wr_data));

    // R3: half write clears the upper half
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slice == 3'd1) |=> regs_q[$past(wr_addr)][DATA_W-1:HALF_W] == '0);

    // R4: 16-bit write keeps bits above 15
    p_word_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slice == 3'd2) |=>
            regs_q[$past(wr_addr)][DATA_W-1:16] == $past(regs_q[wr_addr][DATA_W-1:16]));

    // R5: low byte write keeps bits above 7
    p_byte0_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slice == 3'd3) |=>
            regs_q[$past(wr_addr)][DATA_W-1:8] == $past(regs_q[wr_addr][DATA_W-1:8]));

    // R6: byte 15:8 write takes data[7:0] and keeps the low byte
    p_byte1_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slice == 3'd4) |=>
            (regs_q[$past(wr_addr)][15:8] == $past(wr_data[7:0])) &&
            (regs_q[$past(wr_addr)][7:0] == $past(regs_q[wr_addr][7:0])));

    // R7: reserved codes write nothing
    p_bad_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slice > 3'd4) |=> $stable(regs_q));

    // R8: no enable, no change
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    // R9: read port reflects stored state, never the pending write
    p_read_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_data == regs_q[rd0_addr]);

endmodule

bind prf_regfile prf_regfile_checker #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_slice (wr_slice),
    .wr_data  (wr_data),
    .rd0_addr (rd0_addr),
    .rd0_data (rd0_data),
    .regs_q   (regs_q)
);

// File: tb/prf_regfile_tb.sv
module prf_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [2:0]  wr_slice = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd0_addr = '0;
    logic [63:0] rd0_data;
    logic [2:0]  rd1_addr = '0;
    logic [63:0] rd1_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit summary_done = 1'b0;

    logic [63:0] model [8];

    always #5 clk = ~clk;

    prf_regfile u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_slice (wr_slice),
        .wr_data  (wr_data),
        .rd0_addr (rd0_addr),
        .rd0_data (rd0_data),
        .rd1_addr (rd1_addr),
        .rd1_data (rd1_data)
    );

    // Expected entry after a write, from the requirements
    function automatic logic [63:0] expect_write(logic [63:0] old, logic [2:0] sl, logic [63:0] d);
        logic [63:0] r;
        r = old;
        case (sl)
            3'd0: r = d;
            3'd1: r = {32'h0, d[31:0]};
            3'd2: r[15:0] = d[15:0];
            3'd3: r[7:0] = d[7:0];
            3'd4: r[15:8] = d[7:0];
            default: r = old;
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // drive at falling edge, commit at rising edge, return at next falling edge
    task automatic do_write(logic en, logic [2:0] a, logic [2:0] sl, logic [63:0] d);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_slice = sl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en) model[a] = expect_write(model[a], sl, d);
    endtask

    task automatic read_both(logic [2:0] a0, logic [2:0] a1, string req);
        rd0_addr = a0; rd1_addr = a1;
        #1;
        check(req, rd0_data, model[a0]);
        check(req, rd1_data, model[a1]);
    endtask

    task automatic t_reset_r1();
        for (int i = 0; i < 8; i++) begin
            read_both(i[2:0], 3'(7 - i), "R1");
            check("R1", rd0_data, 64'h0);
        end
    endtask

    task automatic t_full_r2();
        do_write(1'b1, 3'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd0_addr = 3'd1; #1;
        check("R2", rd0_data, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(1'b1, 3'd1, 3'd0, 64'h0123_4567_89AB_CDEF);
        rd0_addr = 3'd1; #1;
        check("R2", rd0_data, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_half_r3();
        do_write(1'b1, 3'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(1'b1, 3'd1, 3'd1, 64'h0);
        rd0_addr = 3'd1; #1;
        check("R3", rd0_data, 64'h0);
        do_write(1'b1, 3'd2, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(1'b1, 3'd2, 3'd1, 64'hAAAA_BBBB_1234_5678);
        rd0_addr = 3'd2; #1;
        check("R3", rd0_data, 64'h0000_0000_1234_5678);
    endtask

    task automatic t_word_r4();
        do_write(1'b1, 3'd3, 3'd0, 64'h1122_3344_5566_7788);
        do_write(1'b1, 3'd3, 3'd2, 64'hDEAD_BEEF_CAFE_ABCD);
        rd0_addr = 3'd3; #1;
        check("R4", rd0_data, 64'h1122_3344_5566_ABCD);
    endtask

    task automatic t_byte0_r5();
        do_write(1'b1, 3'd4, 3'd0, 64'h1122_3344_5566_7788);
        do_write(1'b1, 3'd4, 3'd3, 64'hFFFF_FFFF_FFFF_FF5A);
        rd0_addr = 3'd4; #1;
        check("R5", rd0_data, 64'h1122_3344_5566_775A);
    endtask

    task automatic t_byte1_r6();
        do_write(1'b1, 3'd5, 3'd0, 64'h1122_3344_5566_7788);
        do_write(1'b1, 3'd5, 3'd4, 64'hDEAD_BEEF_0000_99C3);
        rd0_addr = 3'd5; #1;
        check("R6", rd0_data, 64'h1122_3344_5566_C388);
        do_write(1'b1, 3'd5, 3'd4, 64'hFFFF_FFFF_FFFF_FF00);
        rd0_addr = 3'd5; #1;
        check("R6", rd0_data, 64'h1122_3344_5566_0088);
    endtask

    task automatic t_bad_code_r7();
        do_write(1'b1, 3'd6, 3'd0, 64'hA5A5_5A5A_0F0F_F0F0);
        for (int c = 5; c < 8; c++) begin
            do_write(1'b1, 3'd6, c[2:0], 64'h0);
            rd0_addr = 3'd6; #1;
            check("R7", rd0_data, 64'hA5A5_5A5A_0F0F_F0F0);
        end
    endtask

    task automatic t_disabled_r8();
        do_write(1'b0, 3'd6, 3'd0, 64'h0);
        do_write(1'b0, 3'd6, 3'd1, 64'h1234);
        rd0_addr = 3'd6; #1;
        check("R8", rd0_data, 64'hA5A5_5A5A_0F0F_F0F0);
    endtask

    task automatic t_rdw_r9();
        logic [63:0] old;
        old = model[3];
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_slice = 3'd0; wr_data = 64'h7777_6666_5555_4444;
        rd0_addr = 3'd3; rd1_addr = 3'd3;
        #1;
        check("R9", rd0_data, old);
        check("R9", rd1_data, old);
        @(negedge clk);
        wr_en = 1'b0;
        model[3] = 64'h7777_6666_5555_4444;
        #1;
        check("R9", rd0_data, 64'h7777_6666_5555_4444);
    endtask

    task automatic t_ports_r10();
        do_write(1'b1, 3'd7, 3'd0, 64'hFEDC_BA98_7654_3210);
        do_write(1'b1, 3'd0, 3'd2, 64'h0000_0000_0000_BEEF);
        for (int i = 0; i < 8; i++) begin
            read_both(i[2:0], 3'((i + 3) % 8), "R10");
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_full_r2();
        t_half_r3();
        t_word_r4();
        t_byte0_r5();
        t_byte1_r6();
        t_bad_code_r7();
        t_disabled_r8();
        t_rdw_r9();
        t_ports_r10();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        end
        $finish;
    end

    initial begin
        #2000000;
        if (!summary_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary_done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        end
        $finish;
    end

endmodule